// File: doc/BRIEF.md
# Horizontal Drive Pulse Generator with Soft-Start

This block produces the active-high pulse that switches off a line output transistor. A line-position counter runs at the clock rate. It wraps once per line, and a one-cycle sync strobe restarts it. The counter spans 864 ticks at the standard line rate and 432 ticks at the doubled rate. Within each line the pulse rises at a start tick and stays high for 45 percent of the line. The start tick is the sum of a static phase word and a signed per-line offset. A vertical-rate source updates that offset line by line to straighten bowed or tilted vertical lines. The sum is clamped to the allowed shift window and is captured only when a line begins.

When soft-start is selected, the block begins the output stage at roughly twice the line rate once it is enabled. It keeps the high time fixed and lengthens the period by a fixed step on every pulse. When the next period would reach a full line, it waits for the next line boundary and changes to phase-locked operation. If soft-start is not selected, enabling the block leads straight to the line-boundary wait.

Top module: `hd_drive_gen`

## Requirements
- R1: The drive output is 0 while reset is asserted and in any cycle where the enable input is 0.
- R2: In locked operation the pulse repeats every 864 ticks when the rate select is 0 and every 432 ticks when it is 1, with no sync strobes applied.
- R3: In locked operation the high time is floor(line*45/100): 388 ticks at rate 0 and 194 ticks at rate 1.
- R4: In locked operation the pulse rises when the line position equals the latched start tick. Position 0 is the cycle after a sync strobe or a wrap.
- R5: The start tick is phase + offset, where the phase is unsigned and the offset is two's complement. It is clamped to the range 0..61 at rate 0 and 0..30 at rate 1.
- R6: Phase and offset are sampled only at a line start. A change in the middle of a line moves the pulse of the following line, never the current one.
- R7: A sync strobe sets the line position to 0 on the next cycle, whatever the current position.
- R8: When soft-start is selected, the first pulse rises one cycle after enable is sampled. Soft pulses are high for the locked high time. Their periods are half a line at first and grow by 8 ticks per pulse.
- R9: Soft-start ends after the pulse whose period plus 8 would reach one line. The output stays low until the next line start, and locked pulses at the latched start tick follow.
- R10: With soft-start deselected, the first pulse after enable is a full-length locked pulse at the latched start tick.
- R11: Dropping enable during a high phase forces the output low in the same cycle, and it stays low until enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | One-cycle line sync strobe |
| mode_i | input | 1 | 0 = standard line rate, 1 = doubled line rate |
| soft_sel_i | input | 1 | Selects the soft-start sweep after enable |
| en_i | input | 1 | Output stage enable |
| phase_i | input | 7 | Static phase word in ticks |
| ofs_i | input | 8 | Signed per-line phase offset in ticks |
| drive_o | output | 1 | Drive pulse; high turns the transistor off |

## Verification
A wrong line position or a lost sync shows up within one line as a rising edge at the wrong offset from the last strobe. A corrupted high-time or period count shows up on the next pulse as a wrong pulse width or a wrong spacing between rising edges. A start tick latched at the wrong time, or left unclamped, moves the rise in the first or second line after the inputs change. An error in the sweep changes the spacing of the very first soft pulses, and an error in the hand-over misplaces the first locked pulse.

// File: rtl/hd_drive_pkg.sv
package hd_drive_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_SOFT  = 2'd1,
      ST_ALIGN = 2'd2,
      ST_RUN   = 2'd3
   } hd_state_e;

   // total ticks consumed by a sweep from p0 up to (but excluding) lim
   function automatic int unsigned sweep_ticks(input int unsigned p0,
                                               input int unsigned lim,
                                               input int unsigned step);
      int unsigned t;
      int unsigned p;
      t = 0;
      p = p0;
      if (step == 0) return 0;
      while (p < lim) begin
         t = t + p;
         p = p + step;
      end
      return t;
   endfunction

endpackage

// File: rtl/hd_line_timer.sv
module hd_line_timer #(
   parameter int LINE_TICKS = 864,
   parameter int CNT_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             mode_i,
   output logic [CNT_W-1:0] pos_o,
   output logic [CNT_W-1:0] line_len_o,
   output logic             line_start_o
);
   localparam logic [CNT_W-1:0] LEN_STD = CNT_W'(LINE_TICKS);
   localparam logic [CNT_W-1:0] LEN_DBL = CNT_W'(LINE_TICKS / 2);

   logic [CNT_W-1:0] pos_q;

   assign line_len_o   = mode_i ? LEN_DBL : LEN_STD;
   assign line_start_o = sync_i || (pos_q >= line_len_o - CNT_W'(1));
   assign pos_o        = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pos_q <= '0;
      else if (line_start_o) pos_q <= '0;
      else                   pos_q <= pos_q + CNT_W'(1);
   end
endmodule

// File: rtl/hd_phase_sel.sv
module hd_phase_sel #(
   parameter int PHASE_W         = 7,
   parameter int OFS_W           = 8,
   parameter int CNT_W           = 10,
   parameter int MAX_SHIFT_TICKS = 61
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    line_start_i,
   input  logic                    mode_i,
   input  logic [PHASE_W-1:0]      phase_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   output logic [CNT_W-1:0]        start_o
);
   localparam int WIDE  = (PHASE_W + 1 > OFS_W) ? PHASE_W + 1 : OFS_W;
   localparam int SUM_W = ((WIDE > CNT_W) ? WIDE : CNT_W) + 1;
   localparam logic signed [SUM_W-1:0] LIM_STD = SUM_W'(MAX_SHIFT_TICKS);
   localparam logic signed [SUM_W-1:0] LIM_DBL = SUM_W'(MAX_SHIFT_TICKS / 2);

   logic signed [SUM_W-1:0] ph_ext, of_ext, sum, lim;
   logic [CNT_W-1:0]        start_d, start_q;

   assign ph_ext = SUM_W'(phase_i);
   assign of_ext = SUM_W'(ofs_i);
   assign sum    = ph_ext + of_ext;
   assign lim    = mode_i ? LIM_DBL : LIM_STD;

   always_comb begin
      if (sum < 0)        start_d = '0;
      else if (sum > lim) start_d = CNT_W'(lim);
      else                start_d = CNT_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            start_q <= '0;
      else if (line_start_i) start_q <= start_d;
   end

   assign start_o = start_q;
endmodule

// File: rtl/hd_soft_sweep.sv
module hd_soft_sweep #(
   parameter int CNT_W   = 10,
   parameter int SS_STEP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] line_len_i,
   input  logic [CNT_W-1:0] high_i,
   output logic             pulse_o,
   output logic             done_o,
   output logic [CNT_W-1:0] per_o
);
   logic [CNT_W-1:0] cnt_q, per_q;
   logic [CNT_W:0]   per_next;
   logic             per_end;

   assign per_end  = (cnt_q == per_q - CNT_W'(1));
   assign per_next = {1'b0, per_q} + (CNT_W+1)'(SS_STEP);
   assign done_o   = run_i && per_end && (per_next >= {1'b0, line_len_i});
   assign pulse_o  = cnt_q < high_i;
   assign per_o    = per_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
      end else if (kick_i) begin
         cnt_q <= '0;
         per_q <= line_len_i >> 1;
      end else if (run_i) begin
         if (per_end) begin
            cnt_q <= '0;
            per_q <= per_next[CNT_W-1:0];
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/hd_drive_gen.sv
module hd_drive_gen
   import hd_drive_pkg::*;
#(
   parameter int LINE_TICKS      = 864,
   parameter int HIGH_PCT        = 45,
   parameter int MAX_SHIFT_TICKS = 61,
   parameter int SS_STEP         = 8,
   parameter int PHASE_W         = 7,
   parameter int OFS_W           = 8,
   parameter bit HAS_SOFTSTART   = 1'b1,
   parameter int MAX_SWEEP_TICKS = 1147500
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sync_i,
   input  logic                    mode_i,
   input  logic                    soft_sel_i,
   input  logic                    en_i,
   input  logic [PHASE_W-1:0]      phase_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   output logic                    drive_o
);
   localparam int CNT_W    = $clog2(LINE_TICKS + 1);
   localparam int HIGH_STD = LINE_TICKS * HIGH_PCT / 100;
   localparam int HIGH_DBL = (LINE_TICKS / 2) * HIGH_PCT / 100;
   localparam int SWEEP    = sweep_ticks(LINE_TICKS / 2, LINE_TICKS, SS_STEP);

   if (LINE_TICKS % 2 != 0) begin : g_err_odd
      $error("line length must be even");
   end
   if (MAX_SHIFT_TICKS + HIGH_STD >= LINE_TICKS ||
       MAX_SHIFT_TICKS / 2 + HIGH_DBL >= LINE_TICKS / 2) begin : g_err_win
      $error("shifted pulse window must fit inside one line");
   end
   if (SS_STEP < 1 || SWEEP > MAX_SWEEP_TICKS) begin : g_err_sweep
      $error("soft-start step invalid or sweep too long");
   end

   logic [CNT_W-1:0] pos, line_len, start, high_len, ss_per;
   logic             line_start, soft_pulse, soft_done, run_pulse, kick, soft_ok;
   hd_state_e        state, state_d;

   hd_line_timer #(.LINE_TICKS(LINE_TICKS), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode_i(mode_i),
      .pos_o(pos), .line_len_o(line_len), .line_start_o(line_start));

   hd_phase_sel #(.PHASE_W(PHASE_W), .OFS_W(OFS_W), .CNT_W(CNT_W),
                  .MAX_SHIFT_TICKS(MAX_SHIFT_TICKS)) u_phase (
      .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .mode_i(mode_i),
      .phase_i(phase_i), .ofs_i(ofs_i), .start_o(start));

   assign high_len = mode_i ? CNT_W'(HIGH_DBL) : CNT_W'(HIGH_STD);
   assign soft_ok  = HAS_SOFTSTART && soft_sel_i;
   assign kick     = (state == ST_OFF) && en_i && soft_ok;

   if (HAS_SOFTSTART) begin : g_soft
      hd_soft_sweep #(.CNT_W(CNT_W), .SS_STEP(SS_STEP)) u_sweep (
         .clk(clk), .rst_n(rst_n), .kick_i(kick), .run_i(state == ST_SOFT),
         .line_len_i(line_len), .high_i(high_len),
         .pulse_o(soft_pulse), .done_o(soft_done), .per_o(ss_per));
   end else begin : g_nosoft
      assign soft_pulse = 1'b0;
      assign soft_done  = 1'b0;
      assign ss_per     = '0;
   end

   always_comb begin
      state_d = state;
      if (!en_i) state_d = ST_OFF;
      else begin
         unique case (state)
            ST_OFF:   state_d = soft_ok ? ST_SOFT : ST_ALIGN;
            ST_SOFT:  if (soft_done)  state_d = ST_ALIGN;
            ST_ALIGN: if (line_start) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= state_d;
   end

   assign run_pulse = ({1'b0, pos} >= {1'b0, start}) &&
                      ({1'b0, pos} <  ({1'b0, start} + {1'b0, high_len}));

   assign drive_o = en_i && (((state == ST_RUN) && run_pulse) ||
                             ((state == ST_SOFT) && soft_pulse));
endmodule

// File: rtl/hd_drive_gen_chk.sv
module hd_drive_gen_chk
   import hd_drive_pkg::*;
#(
   parameter int CNT_W           = 10,
   parameter int MAX_SHIFT_TICKS = 61
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             sync_i,
   input logic             mode_i,
   input logic             soft_sel_i,
   input logic             drive_o,
   input logic [CNT_W-1:0] pos,
   input logic [CNT_W-1:0] line_len,
   input logic [CNT_W-1:0] start,
   input logic             line_start,
   input hd_state_e        state,
   input logic [CNT_W-1:0] ss_per
);
   localparam logic [CNT_W-1:0] LIM_STD = CNT_W'(MAX_SHIFT_TICKS);
   localparam logic [CNT_W-1:0] LIM_DBL = CNT_W'(MAX_SHIFT_TICKS / 2);

   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !drive_o) else $error("drive high while disabled"); // R1
   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == line_len - CNT_W'(1)) |=> (pos == '0)) else $error("no wrap"); // R2
   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (pos == '0)) else $error("sync ignored"); // R7
   AST_START_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (start <= ($past(mode_i) ? LIM_DBL : LIM_STD))) else $error("start out of range"); // R5
   AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(start)) else $error("start moved mid-line"); // R6
   AST_SOFT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SOFT) |=> ((state != ST_SOFT) || (ss_per >= $past(ss_per)))) else $error("period shrank"); // R8
   AST_RUN_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_RUN) |-> (pos == '0)) else $error("run entered mid-line"); // R9
   AST_DIRECT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_OFF) && en_i && !soft_sel_i) |=> (state == ST_ALIGN)) else $error("soft-start not bypassed"); // R10
endmodule

bind hd_drive_gen hd_drive_gen_chk #(.CNT_W(CNT_W), .MAX_SHIFT_TICKS(MAX_SHIFT_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .sync_i(sync_i), .mode_i(mode_i),
   .soft_sel_i(soft_sel_i), .drive_o(drive_o), .pos(pos), .line_len(line_len),
   .start(start), .line_start(line_start), .state(state), .ss_per(ss_per));

// File: tb/hd_drive_gen_tb.sv
module hd_drive_gen_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  STEP       = 8;

   logic clk = 1'b0, rst_n = 1'b0, sync_i = 1'b0, mode_i = 1'b0;
   logic soft_sel_i = 1'b0, en_i = 1'b0, drive_o;
   logic [6:0] phase_i = '0;
   logic signed [7:0] ofs_i = '0;

   int cyc = 0, checks = 0, errors = 0, sync_cyc = 0;
   bit done = 1'b0;

   hd_drive_gen u_dut (.clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode_i(mode_i),
      .soft_sel_i(soft_sel_i), .en_i(en_i), .phase_i(phase_i), .ofs_i(ofs_i),
      .drive_o(drive_o));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int line_of(input logic m); return m ? 432 : 864; endfunction
   function automatic int high_of(input logic m); return line_of(m) * 45 / 100; endfunction
   function automatic int start_of(input logic m, input int ph, input int of);
      int s = ph + of;
      int lim = m ? 30 : 61;
      if (s < 0) s = 0;
      if (s > lim) s = lim;
      return s;
   endfunction
   function automatic int offs(input int c, input logic m);
      return ((c - sync_cyc) % line_of(m) + line_of(m)) % line_of(m);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_sync();
      @(negedge clk) sync_i = 1'b1;
      @(negedge clk) sync_i = 1'b0;
      sync_cyc = cyc;
   endtask

   task automatic next_rise(output int c);
      logic p = drive_o;
      forever begin
         @(negedge clk);
         if (drive_o && !p) begin c = cyc; return; end
         p = drive_o;
      end
   endtask

   task automatic measure(output int r, output int h);
      next_rise(r);
      while (drive_o) @(negedge clk);
      h = cyc - r;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int r, h, r2, h2, r3, e, bad, nsoft, p;
      int rs[0:63];
      int hs[0:63];
      logic m;
      void'($urandom(32'd2024));

      // R1: reset holds the output low even with enable high
      en_i = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 reset low", drive_o, 0);
      en_i = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      bad = 0;
      repeat (900) begin @(negedge clk); if (drive_o) bad++; end
      chk("R1 disabled low", bad, 0);

      // R10: direct entry, full locked pulse first
      mode_i = 0; soft_sel_i = 0; phase_i = 10; ofs_i = 0;
      do_sync();
      en_i = 1'b1;
      measure(r, h);
      chk("R10 first rise offset", offs(r, 0), 10);
      chk("R10 first pulse high", h, high_of(0));
      measure(r2, h2);
      chk("R2 period std", r2 - r, line_of(0));
      chk("R3 high std", h2, high_of(0));

      // R7: sync mid-line realigns the line
      repeat (300) @(negedge clk);
      do_sync();
      measure(r, h);
      chk("R7 rise after resync", offs(r, 0), 10);

      // R5: clamping corners
      begin
         logic cm[4] = '{1'b0, 1'b0, 1'b1, 1'b1};
         int   cp[4] = '{127, 0, 50, 0};
         int   co[4] = '{100, -50, 0, -1};
         for (int i = 0; i < 4; i++) begin
            mode_i = cm[i]; phase_i = 7'(cp[i]); ofs_i = 8'(co[i]);
            do_sync();
            measure(r, h);
            chk("R5 clamp offset", offs(r, cm[i]), start_of(cm[i], cp[i], co[i]));
            chk("R3 clamp high", h, high_of(cm[i]));
            measure(r2, h2);
            chk("R2 clamp period", r2 - r, line_of(cm[i]));
         end
      end

      // R6: mid-line changes land on the following line only
      mode_i = 0; phase_i = 20; ofs_i = 0;
      do_sync();
      measure(r, h);
      phase_i = 40;
      repeat (864 - (20 + 388) + 10) @(negedge clk);
      phase_i = 5;
      next_rise(r2);
      chk("R6 next line uses new phase", r2 - r, 864 + 20);
      next_rise(r3);
      chk("R6 current line unaffected", r3 - r2, 864 - 35);

      // R11: drop enable inside the high phase
      next_rise(r);
      repeat (5) @(negedge clk);
      en_i = 1'b0;
      #1;
      chk("R11 same-cycle low", drive_o, 0);
      bad = 0;
      repeat (1000) begin @(negedge clk); if (drive_o) bad++; end
      chk("R11 stays low", bad, 0);

      // R8/R9: soft-start sweep
      phase_i = 12; ofs_i = 0; soft_sel_i = 1; mode_i = 0;
      do_sync();
      @(negedge clk) en_i = 1'b1;
      e = cyc;
      nsoft = 0;
      p = 432;
      while (p < 864) begin nsoft++; p += STEP; end
      for (int k = 0; k <= nsoft + 1; k++) measure(rs[k], hs[k]);
      chk("R8 first soft rise", rs[0] - e, 1);
      bad = 0;
      for (int k = 0; k < nsoft; k++) if (hs[k] != 388) bad++;
      chk("R8 soft high constant", bad, 0);
      for (int k = 0; k < nsoft - 1; k++)
         chk("R8 soft period", rs[k+1] - rs[k], 432 + STEP * k);
      chk("R9 locked rise offset", offs(rs[nsoft], 0), 12);
      chk("R9 locked high", hs[nsoft], 388);
      chk("R9 locked period", rs[nsoft+1] - rs[nsoft], 864);

      // R4/R3/R2: random modes, phases, offsets
      for (int i = 0; i < 8; i++) begin
         m = 1'($urandom);
         mode_i = m; phase_i = 7'($urandom); ofs_i = 8'($urandom);
         do_sync();
         measure(r, h);
         chk("R4 random rise offset", offs(r, m), start_of(m, int'(phase_i), int'(ofs_i)));
         chk("R3 random high", h, high_of(m));
         measure(r2, h2);
         chk("R2 random period", r2 - r, line_of(m));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule